// File: doc/BRIEF.md
# Asynchronous Byte-Lane SRAM Controller

This block connects an on-chip requester, clocked by the system clock, to an external asynchronous static RAM. The RAM holds 65,536 words of 16 bits each and has separate upper and lower byte lanes. A request carries a 16-bit word address, 16 bits of write data, a two-bit lane mask and a read/write flag. It is accepted with a valid/ready handshake. The controller then plays out the RAM strobe sequence. Every strobe, address bit and lane enable comes from a flop. Each timing phase lasts a number of clock cycles set by a parameter.

A write lowers chip enable with the address and lane enables in place. After the setup phase it pulses write enable. It then releases write enable for one hold cycle before anything else changes. The controller drives its data lanes only during the strobe and hold cycles, and output enable stays high for the whole write. A read holds chip enable and output enable low for the data-wait phase. It captures the bus on the last cycle of that phase and returns the word with a one-cycle response pulse. A turnaround phase with the RAM deselected follows every read, so the RAM has released the bus before the controller can drive it again. A request whose mask is all zero completes at once and asserts no strobe.

The defaults are one setup cycle, one strobe cycle, two data-wait cycles and one turnaround cycle. At a 100 MHz clock these meet a 10 ns RAM: write cycle 10 ns, write pulse 7 ns, address valid 8 ns before the end of the write, data valid 5 ns before it, zero hold. Each phase parameter must be at least 1.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, chip enable, write enable, output enable and both lane enables are high. No data lane is driven, req_ready_o is high and rsp_valid_o is low.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both high. req_ready_o is high exactly when no access is in progress, and it returns high in the cycle after the last cycle of an access.
- R3: A write with a non-zero mask runs in this order. First, SETUP_CYC cycles with chip enable low and write enable high. Next, STROBE_CYC cycles with write enable low. Last, one hold cycle with write enable high and chip enable, lane enables, address and data unchanged. Chip enable then goes high. Output enable stays high throughout.
- R4: Mask bit 0 selects data bits 7:0 and drives sram_be_no[0] low. Mask bit 1 selects bits 15:8 and drives sram_be_no[1] low. A lane whose mask bit is 0 keeps its enable high, is not driven, is not written, and reads back as zero in rsp_rdata_o.
- R5: A read with a non-zero mask holds chip enable and output enable low, with write enable high, for RD_CYC cycles. The bus is captured on the last of those cycles. rsp_valid_o is then high for exactly one cycle, carrying the captured lanes.
- R6: After a read, chip enable and output enable stay high for TURN_CYC cycles before the next request can be accepted. No data lane is driven within TURN_CYC cycles of output enable rising.
- R7: A data lane is driven only while chip enable is low and output enable is high, and only in the strobe and hold cycles of a write.
- R8: A request with an all-zero mask asserts no strobe, leaves req_ready_o high and changes no RAM contents. A zero-mask read pulses rsp_valid_o in the next cycle with rsp_rdata_o equal to zero.
- R9: While chip enable stays low, the address and the lane enables do not change. Data does not change while it is being driven.
- R10: A write never produces a response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request accepted on this edge if valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_mask_i | input | DATA_W/8 | Lane mask, bit 0 = bits 7:0 |
| rsp_valid_o | output | 1 | One-cycle read response strobe |
| rsp_rdata_o | output | DATA_W | Read data, unselected lanes zero |
| sram_addr_o | output | ADDR_W | RAM address |
| sram_ce_no | output | 1 | RAM chip enable, active low |
| sram_we_no | output | 1 | RAM write enable, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_be_no | output | DATA_W/8 | RAM lane enables, active low, bit 0 = lower lane |
| sram_dq_o | output | DATA_W | Data toward the RAM pad drivers |
| sram_dq_i | input | DATA_W | Data from the RAM pads |
| sram_dq_oe_o | output | DATA_W/8 | Per-lane pad driver enable, active high |

## Verification
On every cycle, the assertions check the strobe ordering rules. These are: write enable only inside chip enable, write enable released before chip enable, and pad drivers only with output enable high. They also check that the address and lanes stay stable under chip enable, that the idle state has every strobe high, and the turnaround gap between a read and the next driven lane. The bench's scenarios are needed for the things that depend on stored contents and exact phase lengths. These are the lane merges from partial writes, zero lanes in masked reads, zero-mask requests leaving memory unchanged, boundary addresses, and the exact cycle in which each strobe and response appears.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RDWAIT,
    PH_TURN
  } phase_e;

  // chip selected in this phase
  function automatic logic ph_selected(phase_e p);
    return (p == PH_SETUP) || (p == PH_STROBE) || (p == PH_HOLD) || (p == PH_RDWAIT);
  endfunction

  // pad drivers allowed in this phase
  function automatic logic ph_drive(phase_e p);
    return (p == PH_STROBE) || (p == PH_HOLD);
  endfunction

endpackage

// File: rtl/sram_ctrl_req.sv
module sram_ctrl_req #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  mask_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  mask_o,
  output logic [LANES-1:0]  mask_nxt_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      mask_q  <= mask_i;
    end
  end

  assign addr_o     = addr_q;
  assign wdata_o    = wdata_q;
  assign mask_o     = mask_q;
  assign mask_nxt_o = accept_i ? mask_i : mask_q;

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 1,
  parameter int unsigned RD_CYC     = 2,
  parameter int unsigned TURN_CYC   = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   accept_i,
  input  logic   write_i,
  input  logic   mask_nz_i,
  output phase_e phase_d_o,
  output logic   capture_o,
  output logic   idle_o
);

  localparam int unsigned MAX_WR = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int unsigned MAX_RD = (RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC;
  localparam int unsigned MAX_C  = (MAX_WR > MAX_RD) ? MAX_WR : MAX_RD;
  localparam int unsigned CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last = (cnt_q == '0);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = last ? '0 : cnt_q - CNT_W'(1);
    unique case (ph_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (accept_i && mask_nz_i) begin
          if (write_i) begin
            ph_d  = PH_SETUP;
            cnt_d = CNT_W'(SETUP_CYC - 1);
          end else begin
            ph_d  = PH_RDWAIT;
            cnt_d = CNT_W'(RD_CYC - 1);
          end
        end
      end
      PH_SETUP: if (last) begin
        ph_d  = PH_STROBE;
        cnt_d = CNT_W'(STROBE_CYC - 1);
      end
      PH_STROBE: if (last) begin
        ph_d  = PH_HOLD;
        cnt_d = '0;
      end
      PH_HOLD: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
      PH_RDWAIT: if (last) begin
        ph_d  = PH_TURN;
        cnt_d = CNT_W'(TURN_CYC - 1);
      end
      PH_TURN: if (last) ph_d = PH_IDLE;
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_d_o = ph_d;
  assign capture_o = (ph_q == PH_RDWAIT) && last;
  assign idle_o    = (ph_q == PH_IDLE);

endmodule

// File: rtl/sram_ctrl_lane.sv
module sram_ctrl_lane
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_d_i,
  input  logic              lane_en_i,
  input  logic              cap_i,
  input  logic              cap_keep_i,
  input  logic [LANE_W-1:0] dq_i,
  output logic              be_no,
  output logic              dq_oe_o,
  output logic [LANE_W-1:0] rdata_o
);

  logic              be_n_q;
  logic              oe_q;
  logic [LANE_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      be_n_q <= 1'b1;
      oe_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      be_n_q <= !(ph_selected(phase_d_i) && lane_en_i);
      oe_q   <= ph_drive(phase_d_i) && lane_en_i;
      if (cap_i) rd_q <= cap_keep_i ? dq_i : '0;
    end
  end

  assign be_no   = be_n_q;
  assign dq_oe_o = oe_q;
  assign rdata_o = rd_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 1,
  parameter int unsigned RD_CYC     = 2,
  parameter int unsigned TURN_CYC   = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [DATA_W/8-1:0] req_mask_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic [ADDR_W-1:0]   sram_addr_o,
  output logic                sram_ce_no,
  output logic                sram_we_no,
  output logic                sram_oe_no,
  output logic [DATA_W/8-1:0] sram_be_no,
  output logic [DATA_W-1:0]   sram_dq_o,
  input  logic [DATA_W-1:0]   sram_dq_i,
  output logic [DATA_W/8-1:0] sram_dq_oe_o
);

  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned LANE_W = 8;

  logic             idle, accept, zero_rd, capture;
  phase_e           phase_d;
  logic [LANES-1:0] mask_q, mask_nxt;
  logic             ce_n_q, we_n_q, oe_n_q, rsp_q;

  assign accept  = req_valid_i && idle;
  assign zero_rd = accept && !req_write_i && (req_mask_i == '0);

  sram_ctrl_req #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .mask_i     (req_mask_i),
    .addr_o     (sram_addr_o),
    .wdata_o    (sram_dq_o),
    .mask_o     (mask_q),
    .mask_nxt_o (mask_nxt)
  );

  sram_ctrl_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .RD_CYC     (RD_CYC),
    .TURN_CYC   (TURN_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .write_i   (req_write_i),
    .mask_nz_i (|req_mask_i),
    .phase_d_o (phase_d),
    .capture_o (capture),
    .idle_o    (idle)
  );

  // strobes registered from the next phase so pins never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      rsp_q  <= 1'b0;
    end else begin
      ce_n_q <= !ph_selected(phase_d);
      we_n_q <= (phase_d != PH_STROBE);
      oe_n_q <= (phase_d != PH_RDWAIT);
      rsp_q  <= capture || zero_rd;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sram_ctrl_lane #(
      .LANE_W (LANE_W)
    ) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .phase_d_i  (phase_d),
      .lane_en_i  (mask_nxt[i]),
      .cap_i      (capture || zero_rd),
      .cap_keep_i (capture && mask_q[i]),
      .dq_i       (sram_dq_i[i*LANE_W +: LANE_W]),
      .be_no      (sram_be_no[i]),
      .dq_oe_o    (sram_dq_oe_o[i]),
      .rdata_o    (rsp_rdata_o[i*LANE_W +: LANE_W])
    );
  end

  assign req_ready_o = idle;
  assign rsp_valid_o = rsp_q;
  assign sram_ce_no  = ce_n_q;
  assign sram_we_no  = we_n_q;
  assign sram_oe_no  = oe_n_q;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned LANES    = 2,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TURN_CYC = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce_no,
  input logic              sram_we_no,
  input logic              sram_oe_no,
  input logic [LANES-1:0]  sram_be_no,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic [LANES-1:0]  sram_dq_oe_o
);

  localparam int unsigned GAP_MAX = TURN_CYC + 1;
  localparam int unsigned GAP_W   = $clog2(GAP_MAX + 1);

  logic [GAP_W-1:0] gap_q;

  // cycles with output enable high, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= GAP_W'(GAP_MAX);
    else if (!sram_oe_no) gap_q <= '0;
    else if (gap_q != GAP_W'(GAP_MAX)) gap_q <= gap_q + GAP_W'(1);
  end

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_ce_no && sram_we_no && sram_oe_no));

  assert_we_inside_ce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_ce_no && sram_oe_no));

  assert_we_release_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> !sram_ce_no);

  assert_ce_fall_we_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_ce_no) |-> sram_we_no);

  assert_off_lane_undriven_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o & sram_be_no) == '0);

  assert_rsp_deselected_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (sram_ce_no && sram_oe_no));

  assert_turnaround_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|sram_dq_oe_o) |-> (gap_q > GAP_W'(TURN_CYC)));

  assert_drive_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sram_dq_oe_o) |-> (sram_oe_no && !sram_ce_no));

  assert_stable_select_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> ($stable(sram_addr_o) && $stable(sram_be_no)));

  assert_stable_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|sram_dq_oe_o) && $past(|sram_dq_oe_o)) |-> $stable(sram_dq_o));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .LANES    (DATA_W / 8),
  .DATA_W   (DATA_W),
  .TURN_CYC (TURN_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_ce_no   (sram_ce_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no),
  .sram_be_no   (sram_be_no),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  localparam int S = 2;
  localparam int W = 2;
  localparam int R = 3;
  localparam int T = 2;

  typedef struct {
    bit          w;
    logic [15:0] a;
    logic [15:0] d;
    logic [1:0]  m;
    int          gap;
  } op_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [1:0]  req_mask_i = '0;
  logic        rsp_valid_o;
  logic [15:0] rsp_rdata_o;
  logic [15:0] sram_addr_o;
  logic        sram_ce_no, sram_we_no, sram_oe_no;
  logic [1:0]  sram_be_no;
  logic [15:0] sram_dq_o;
  logic [15:0] bus_q = '0;
  logic [1:0]  sram_dq_oe_o;

  int checks = 0;
  int fails  = 0;

  logic [15:0] mem    [int];
  logic [15:0] shadow [int];
  op_t         ops    [$];

  always #2 clk_i = ~clk_i;

  sram_ctrl #(
    .ADDR_W (16), .DATA_W (16),
    .SETUP_CYC (S), .STROBE_CYC (W), .RD_CYC (R), .TURN_CYC (T)
  ) u_dut (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .req_valid_i (req_valid_i), .req_ready_o (req_ready_o),
    .req_write_i (req_write_i), .req_addr_i (req_addr_i),
    .req_wdata_i (req_wdata_i), .req_mask_i (req_mask_i),
    .rsp_valid_o (rsp_valid_o), .rsp_rdata_o (rsp_rdata_o),
    .sram_addr_o (sram_addr_o), .sram_ce_no (sram_ce_no),
    .sram_we_no (sram_we_no), .sram_oe_no (sram_oe_no),
    .sram_be_no (sram_be_no), .sram_dq_o (sram_dq_o),
    .sram_dq_i (bus_q), .sram_dq_oe_o (sram_dq_oe_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_mem(logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  function automatic logic [15:0] rd_shadow(logic [15:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
  endfunction

  task automatic add(bit w, logic [15:0] a, logic [15:0] d, logic [1:0] m, int gap);
    op_t o;
    o.w = w; o.a = a; o.d = d; o.m = m; o.gap = gap;
    ops.push_back(o);
  endtask

  initial begin
    int          m_t = 0;
    int          busy = 0;
    bit          cw = 1'b0;
    logic [1:0]  cm = '0;
    logic [15:0] ca = '0, cd = '0, crd = '0;
    int          gap_cnt = 0;
    int          cyc = 0;
    int          tail = 0;

    // R1: reset state
    repeat (3) begin
      @(negedge clk_i);
      chk("R1", "ce_n", sram_ce_no, 1);
      chk("R1", "we_n", sram_we_no, 1);
      chk("R1", "oe_n", sram_oe_no, 1);
      chk("R1", "be_n", sram_be_no, 2'b11);
      chk("R1", "dq_oe", sram_dq_oe_o, 0);
      chk("R1", "rsp_valid", rsp_valid_o, 0);
    end
    rst_ni = 1'b1;

    add(1, 16'h0010, 16'h1234, 2'b11, 0);
    add(0, 16'h0010, 16'h0000, 2'b11, 2);
    add(1, 16'h0010, 16'h77AB, 2'b01, 0);
    add(0, 16'h0010, 16'h0000, 2'b11, 0);
    add(1, 16'h0010, 16'hCD99, 2'b10, 1);
    add(0, 16'h0010, 16'h0000, 2'b11, 0);
    add(0, 16'h0010, 16'h0000, 2'b01, 0);
    add(0, 16'h0010, 16'h0000, 2'b10, 0);
    add(1, 16'h0010, 16'hFFFF, 2'b00, 0);
    add(0, 16'h0010, 16'h0000, 2'b00, 0);
    add(0, 16'h0010, 16'h0000, 2'b11, 0);
    add(1, 16'hFFFF, 16'h5A5A, 2'b11, 0);
    add(1, 16'h0000, 16'hA5C3, 2'b11, 0);
    add(0, 16'hFFFF, 16'h0000, 2'b11, 0);
    add(1, 16'hFFFF, 16'h0F0F, 2'b11, 0);
    add(0, 16'h0000, 16'h0000, 2'b11, 0);
    add(0, 16'hFFFF, 16'h0000, 2'b11, 0);
    add(0, 16'h1234, 16'h0000, 2'b11, 3);

    forever begin
      logic       e_ready, e_ce, e_we, e_oe, e_rsp;
      logic [1:0] e_be, e_dqoe;
      string      tg;
      bit         active;

      @(negedge clk_i);
      cyc++;
      if (cyc > 20000) begin
        chk("R2", "watchdog", 0, 1);
        break;
      end

      // expected outputs from the behavioural model
      active  = (m_t != 0) && (m_t <= busy);
      e_ready = !active;
      e_ce = 1; e_we = 1; e_oe = 1; e_be = 2'b11; e_dqoe = 2'b00;
      if (active && cw) begin
        e_ce = 0; e_be = ~cm;
        if (m_t > S && m_t <= S + W) e_we = 0;
        if (m_t > S) e_dqoe = cm;
      end else if (active && m_t <= R) begin
        e_ce = 0; e_oe = 0; e_be = ~cm;
      end
      e_rsp = (m_t != 0) && !cw && (((cm != 0) && (m_t == R + 1)) || ((cm == 0) && (m_t == 1)));
      if (m_t == 0)       tg = "R2";
      else if (cm == 0)   tg = "R8";
      else if (cw)        tg = "R3";
      else if (m_t > R)   tg = "R6";
      else                tg = "R5";

      chk("R2", "ready", req_ready_o, e_ready);
      chk(tg, "ce_n", sram_ce_no, e_ce);
      chk(tg, "we_n", sram_we_no, e_we);
      chk(tg, "oe_n", sram_oe_no, e_oe);
      chk("R4", "be_n", sram_be_no, e_be);
      chk("R7", "dq_oe", sram_dq_oe_o, e_dqoe);
      chk(cw ? "R10" : tg, "rsp_valid", rsp_valid_o, e_rsp);
      if (e_rsp) chk((cm == 0) ? "R8" : "R4", "rdata", rsp_rdata_o, crd);
      if (!e_ce) chk("R9", "addr", sram_addr_o, ca);
      for (int l = 0; l < 2; l++)
        if (e_dqoe[l]) chk("R9", "wdata", sram_dq_o[l*8 +: 8], cd[l*8 +: 8]);

      // RAM model: write capture, contention, read drive
      for (int l = 0; l < 2; l++) begin
        logic [15:0] tmp;
        logic        drv;
        if (!sram_ce_no && !sram_we_no && !sram_be_no[l]) begin
          tmp = rd_mem(sram_addr_o);
          tmp[l*8 +: 8] = sram_dq_oe_o[l] ? sram_dq_o[l*8 +: 8] : 8'hEE;
          mem[int'(sram_addr_o)] = tmp;
        end
        drv = !sram_ce_no && !sram_oe_no && sram_we_no && !sram_be_no[l];
        if (sram_dq_oe_o[l]) chk("R7", "contention", drv, 0);
        bus_q[l*8 +: 8] = sram_dq_oe_o[l] ? sram_dq_o[l*8 +: 8]
                        : (drv ? rd_mem(sram_addr_o) >> (l*8) : 8'h00);
      end

      // stimulus for the next edge and model advance
      if (gap_cnt > 0) begin
        gap_cnt--;
        req_valid_i = 1'b0;
        if (m_t != 0 && m_t < 1000) m_t++;
      end else if (ops.size() != 0) begin
        op_t o;
        o = ops[0];
        req_valid_i = 1'b1;
        req_write_i = o.w;
        req_addr_i  = o.a;
        req_wdata_i = o.d;
        req_mask_i  = o.m;
        if (e_ready) begin
          void'(ops.pop_front());
          gap_cnt = o.gap;
          cw = o.w; cm = o.m; ca = o.a; cd = o.d;
          busy = (o.m == 0) ? 0 : (o.w ? S + W + 1 : R + T);
          crd = '0;
          for (int l = 0; l < 2; l++) begin
            logic [15:0] s;
            s = rd_shadow(o.a);
            if (o.m[l]) begin
              if (o.w) begin
                s[l*8 +: 8] = o.d[l*8 +: 8];
                shadow[int'(o.a)] = s;
              end else begin
                crd[l*8 +: 8] = s[l*8 +: 8];
              end
            end
          end
          m_t = 1;
        end else if (m_t != 0 && m_t < 1000) m_t++;
      end else begin
        req_valid_i = 1'b0;
        if (m_t != 0 && m_t < 1000) m_t++;
        if (e_ready && gap_cnt == 0) begin
          tail++;
          if (tail > 4) break;
        end
      end
    end

    // R8: zero-mask write left memory unchanged; R4 lane merge in RAM model
    chk("R8", "mem_0010", rd_mem(16'h0010), 16'hCDAB);
    chk("R4", "mem_ffff", rd_mem(16'hFFFF), 16'h0F0F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule